// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a master for a three-wire serial EEPROM with a Microwire-style interface. It fetches one 16-bit word from the address given when a start pulse arrives. The block drives the chip select, shift clock and data-in pins, and it samples the data-out pin. The read command is built as the address ORed with the three-bit read opcode shifted left by the address length. The opcode is `110`, and its leading 1 serves as the start bit. This word is sent most significant bit first. The block then clocks in sixteen data bits, releases the chip select and raises a one-cycle done pulse.

The address length is set by a parameter, normally 6 or 8 bits. The length of each shift-clock phase is a second parameter, counted in system clocks. A slow EEPROM can therefore be served from a fast system clock. The write opcode `101` and the erase opcode `111` are defined in the shared package for later command sequencing. This block only issues reads.

Top module: `eeprom_word_reader`

## Requirements
- R1: While reset is held, chip select, shift clock, data-in, done and the read word are all zero.
- R2: The command is the 3 + ADDR_W bit value {1,1,0, addr}, which equals addr OR (6 shifted left by ADDR_W). It is sent MSB first, one bit on each shift-clock rising edge.
- R3: After a start, chip select stays low for one phase and then rises with the shift clock and data-in both low. It is first seen high PHASE_CYC + 1 sampling points after the cycle in which start is driven.
- R4: Data-in changes only while the shift clock is low and is held for the whole high phase. The shift clock rises only while chip select is high.
- R5: Every interval between consecutive shift-clock transitions within an access lasts exactly PHASE_CYC system clocks.
- R6: After the last command bit, the shift clock stays low for one phase. Then 16 data bits are clocked in MSB first, each sampled at the end of its high phase. Exactly 3 + ADDR_W + 16 rising edges occur per access.
- R7: Data-in is held low from the end of the last command high phase until the access ends.
- R8: Chip select drops after the last data bit. Done is high for exactly one cycle, in the cycle in which chip select first reads low.
- R9: The read word changes only in the cycle in which done is high, and it holds its value until the next access completes.
- R10: A start pulse that arrives during an access is ignored. It starts no second access and does not change the word being fetched.
- R11: With ADDR_W = 8 and PHASE_CYC = 1, the same sequence is produced with an 11-bit command and single-clock phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a read; sampled only when idle |
| addr | input | ADDR_W | Word address, captured with start |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| rd_data | output | 16 | Last word read |
| done | output | 1 | One-cycle pulse when an access ends |

## Verification
The bench targets four failure modes.

- **Phase boundaries.** An off-by-one phase counter shows up as a high or low run shorter or longer than PHASE_CYC. The most likely places are the turnaround phase after the command and the single-clock configuration.
- **Command assembly.** An opcode shifted by the wrong amount, or bits sent LSB first, corrupts the captured command and yields the wrong word. An extra or missing data edge has the same visible effect.
- **Data-in during the read phase.** A design that lets the last command bit linger on data-in during the read phase leaves data-in high where it must be low.
- **Done pulse, stored word and retriggering.** A design that retriggers on a mid-access start produces a second done pulse or fetches the wrong address. A done pulse that is stretched or misaligned with chip select is reported, as is a word that changes outside the done cycle.

// File: rtl/eeprom_rd_pkg.sv
// Shared types and constants for the serial EEPROM word reader.
// Assumes a three-wire device whose opcodes carry their own start bit.
package eeprom_rd_pkg;

    localparam int WORD_W = 16;

    // Three-bit opcodes; the leading 1 in each is the start bit.
    localparam logic [2:0] OPC_READ  = 3'b110;
    localparam logic [2:0] OPC_WRITE = 3'b101;
    localparam logic [2:0] OPC_ERASE = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for start, all pins low
        ST_DESEL,   // one phase with select low before the access
        ST_SELECT,  // select high, clock low, data-in low
        ST_CMD,     // shifting the command word out
        ST_TURN,    // one low clock phase between command and data
        ST_DATA,    // shifting the data word in
        ST_FIN      // select released, done pulse
    } seq_state_t;

endpackage

// File: rtl/ee_phase_timer.sv
// Phase timer: while run is high, raises tick on the last system clock of
// every PHASE_CYC-long phase. Assumes PHASE_CYC >= 1; cleared when run is low.
module ee_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    logic [CW-1:0] cnt;

    // End of phase when the count reaches its last value.
    assign tick = run && (cnt == CW'(PHASE_CYC - 1));

    // Count system clocks inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ee_shift_out.sv
// Parallel-load, MSB-first shift register for the outgoing command.
// Assumes load and shift are never requested in the same cycle.
module ee_shift_out #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sr;

    assign msb = sr[W-1];

    // Load the command word, then move it left one bit per request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= din;
        else if (shift)
            sr <= {sr[W-2:0], 1'b0};
    end
endmodule

// File: rtl/ee_shift_in.sv
// Serial-in register collecting the incoming word MSB first.
// Assumes exactly W enables per access after a clear.
module ee_shift_in #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    // Clear at access start, append one sampled bit per enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/eeprom_word_reader.sv
// Serial EEPROM word reader. On start, it selects the device, shifts out the
// read command {110, addr} MSB first, clocks in 16 data bits, then releases
// select and pulses done. Every shift-clock phase lasts PHASE_CYC clocks.
// Assumes ee_do is already synchronous to clk; start is ignored while busy.
module eeprom_word_reader
    import eeprom_rd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [WORD_W-1:0] rd_data,
    output logic              done
);
    localparam int CMD_W  = ADDR_W + 3;
    localparam int MAXB   = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int BCNT_W = $clog2(MAXB);

    seq_state_t        state;
    logic              half;      // 1 while the shift clock is high
    logic [BCNT_W-1:0] bcnt;
    logic              tick;
    logic              run;
    logic              cmd_msb;
    logic              cmd_load;
    logic              cmd_shift;
    logic              dat_en;
    logic [WORD_W-1:0] dat_q;
    logic [CMD_W-1:0]  cmd_word;

    // Command = address ORed with the read opcode placed above it.
    assign cmd_word  = (CMD_W'(OPC_READ) << ADDR_W) | CMD_W'(addr);

    // Timer runs during every timed phase of an access.
    assign run       = (state != ST_IDLE) && (state != ST_FIN);
    assign cmd_load  = (state == ST_IDLE) && start;
    assign cmd_shift = (state == ST_CMD) && tick && half;
    assign dat_en    = (state == ST_DATA) && tick && half;

    ee_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    ee_shift_out #(.W(CMD_W)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_load),
        .shift (cmd_shift),
        .din   (cmd_word),
        .msb   (cmd_msb)
    );

    ee_shift_in #(.W(WORD_W)) u_dat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd_load),
        .en     (dat_en),
        .bit_in (ee_do),
        .q      (dat_q)
    );

    // Access sequencer: phase order, clock half and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            half    <= 1'b0;
            bcnt    <= '0;
            rd_data <= '0;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_DESEL;
                ST_DESEL:  if (tick)  state <= ST_SELECT;
                ST_SELECT: if (tick) begin
                    state <= ST_CMD;
                    half  <= 1'b0;
                    bcnt  <= '0;
                end
                ST_CMD: if (tick) begin
                    if (!half) begin
                        half <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        if (bcnt == BCNT_W'(CMD_W - 1))
                            state <= ST_TURN;
                        else
                            bcnt <= bcnt + 1'b1;
                    end
                end
                ST_TURN: if (tick) begin
                    state <= ST_DATA;
                    half  <= 1'b1;
                    bcnt  <= '0;
                end
                ST_DATA: if (tick) begin
                    if (half) begin
                        half <= 1'b0;
                    end else if (bcnt == BCNT_W'(WORD_W - 1)) begin
                        state   <= ST_FIN;
                        rd_data <= dat_q;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                        half <= 1'b1;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin decode from the sequencer state.
    always_comb begin
        ee_cs = (state == ST_SELECT) || (state == ST_CMD) ||
                (state == ST_TURN)   || (state == ST_DATA);
        ee_sk = half && ((state == ST_CMD) || (state == ST_DATA));
        ee_di = (state == ST_CMD) && cmd_msb;
        done  = (state == ST_FIN);
    end
endmodule

// File: rtl/eeprom_word_reader_chk.sv
// Protocol checker for the serial EEPROM word reader, bound to every instance.
// Observes pins only; assumes synchronous active-low reset.
module eeprom_word_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ee_cs,
    input logic        ee_sk,
    input logic        ee_di,
    input logic        done,
    input logic [15:0] rd_data
);
    // R4: the shift clock only rises inside a selected access.
    p_sk_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> ee_cs);

    // R4: data-in is steady across a high clock phase.
    p_di_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R8: done appears exactly when chip select has just fallen.
    p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_cs && $past(ee_cs)));

    // R8: a falling chip select always comes with done.
    p_release_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> done);

    // R8: done lasts one cycle.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the stored word moves only with done.
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
endmodule

bind eeprom_word_reader eeprom_word_reader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/sim_eeprom_word_reader.sv
// Behavioural EEPROM model: captures the command and serves a computed word.
// It also flags data-in activity during the read and wrong phase lengths.
module ee_bench_model #(
    parameter int AW = 6,
    parameter int P  = 2
) (
    input  logic          clk,
    input  logic          cs,
    input  logic          sk,
    input  logic          di,
    output logic          do_o,
    output logic [15:0]   cmd_cap,
    output int            edges,
    output logic          di_bad,
    output logic          phase_bad
);
    localparam int CW = AW + 3;

    logic cs_prev = 1'b0;
    logic sk_prev = 1'b0;
    logic have_edge = 1'b0;
    int   run_len = 0;
    logic [15:0] word;

    function automatic logic [15:0] ee_word(int a);
        return 16'(a * 32'h2F1B) ^ 16'hC35A;
    endfunction

    initial begin
        do_o = 1'b0; cmd_cap = '0; edges = 0; di_bad = 1'b0; phase_bad = 1'b0;
        word = '0;
    end

    // Track one access on the falling system-clock edge.
    always @(negedge clk) begin
        if (cs && !cs_prev) begin
            edges = 0; cmd_cap = '0; di_bad = 1'b0; phase_bad = 1'b0;
            have_edge = 1'b0; run_len = 0; sk_prev = 1'b0;
        end
        if (cs) begin
            if (sk != sk_prev) begin
                if (have_edge && run_len != P) phase_bad = 1'b1;
                have_edge = 1'b1;
                run_len = 1;
                if (sk) begin
                    if (edges < CW) begin
                        cmd_cap = {cmd_cap[14:0], di};
                    end else begin
                        word = ee_word(int'(cmd_cap[AW-1:0]));
                        do_o = word[15 - (edges - CW)];
                    end
                    edges = edges + 1;
                end
            end else begin
                run_len = run_len + 1;
            end
            if (di && ((edges > CW) || (edges == CW && !sk))) di_bad = 1'b1;
        end
        cs_prev = cs;
        sk_prev = sk;
    end
endmodule

// Directed bench for the word reader: u0 has 6 address bits and 3-clock phases,
// u1 has 8 address bits and 1-clock phases.
module sim_eeprom_word_reader;
    localparam int WD_CYC = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        start0 = 1'b0, start1 = 1'b0;
    logic [5:0]  addr0 = '0;
    logic [7:0]  addr1 = '0;
    logic        cs0, sk0, di0, do0, done0;
    logic        cs1, sk1, di1, do1, done1;
    logic [15:0] rd0, rd1;
    logic [15:0] cap0, cap1;
    int          edg0, edg1;
    logic        dib0, dib1, phb0, phb1;
    int          dcnt0 = 0, dcnt1 = 0;
    int          n_chk = 0, n_err = 0;

    eeprom_word_reader #(.ADDR_W(6), .PHASE_CYC(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .addr(addr0), .ee_do(do0),
        .ee_cs(cs0), .ee_sk(sk0), .ee_di(di0), .rd_data(rd0), .done(done0));

    eeprom_word_reader #(.ADDR_W(8), .PHASE_CYC(1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .addr(addr1), .ee_do(do1),
        .ee_cs(cs1), .ee_sk(sk1), .ee_di(di1), .rd_data(rd1), .done(done1));

    ee_bench_model #(.AW(6), .P(3)) m0 (
        .clk(clk), .cs(cs0), .sk(sk0), .di(di0), .do_o(do0), .cmd_cap(cap0),
        .edges(edg0), .di_bad(dib0), .phase_bad(phb0));

    ee_bench_model #(.AW(8), .P(1)) m1 (
        .clk(clk), .cs(cs1), .sk(sk1), .di(di1), .do_o(do1), .cmd_cap(cap1),
        .edges(edg1), .di_bad(dib1), .phase_bad(phb1));

    always @(negedge clk) begin
        if (done0) dcnt0++;
        if (done1) dcnt1++;
    end

    function automatic logic [15:0] exp_word(int a);
        return 16'(a * 32'h2F1B) ^ 16'hC35A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    // R1: all outputs quiet during reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({cs0, sk0, di0, done0} == 4'b0 && rd0 == 16'h0, "R1", "u0 pins in reset",
              {cs0, sk0, di0, done0, rd0}, 0);
        check({cs1, sk1, di1, done1} == 4'b0 && rd1 == 16'h0, "R1", "u1 pins in reset",
              {cs1, sk1, di1, done1, rd1}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One read on the chosen instance; poke drives a second start mid-access (R10).
    task automatic t_read(input bit which, input int a, input bit poke);
        int p       = which ? 1 : 3;
        int aw      = which ? 8 : 6;
        int cw      = aw + 3;
        int waited  = 0;
        int d_before;
        logic [15:0] exp_cmd = 16'((32'd6 << aw) | a);
        logic [15:0] word_now;
        d_before = which ? dcnt1 : dcnt0;
        if (which) begin start1 = 1'b1; addr1 = 8'(a); end
        else       begin start0 = 1'b1; addr0 = 6'(a); end
        @(negedge clk);
        start0 = 1'b0; start1 = 1'b0;
        waited = 1;
        while (!(which ? cs1 : cs0) && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        // R3: select rises after one deselected phase, clock and data low.
        check(waited == p + 1, "R3", "cycles to select", waited, p + 1);
        check((which ? {sk1, di1} : {sk0, di0}) == 2'b00, "R3", "clock/data at select",
              which ? {sk1, di1} : {sk0, di0}, 0);
        if (poke) begin
            repeat (4) @(negedge clk);
            if (which) begin start1 = 1'b1; addr1 = 8'(a ^ 1); end
            else       begin start0 = 1'b1; addr0 = 6'(a ^ 1); end
            @(negedge clk);
            start0 = 1'b0; start1 = 1'b0;
        end
        waited = 0;
        while (!(which ? done1 : done0) && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 2000, "R8", "done seen", waited, 0);
        // R8: select low while done is high.
        check(!(which ? cs1 : cs0), "R8", "select at done", which ? cs1 : cs0, 0);
        // R2: captured command bits, MSB first, start bit leading.
        check((which ? cap1 : cap0) == exp_cmd, "R2", "command word",
              which ? cap1 : cap0, exp_cmd);
        // R6: number of clock rising edges.
        check((which ? edg1 : edg0) == cw + 16, "R6", "rising edges",
              which ? edg1 : edg0, cw + 16);
        // R5: phase lengths.
        check(!(which ? phb1 : phb0), "R5", "phase length error", which ? phb1 : phb0, 0);
        // R7: data-in low during the read phase.
        check(!(which ? dib1 : dib0), "R7", "data-in high in read", which ? dib1 : dib0, 0);
        // R6 / R11: word assembled MSB first.
        word_now = which ? rd1 : rd0;
        check(word_now == exp_word(a), which ? "R11" : "R6", "read word",
              word_now, exp_word(a));
        @(negedge clk);
        check(!(which ? done1 : done0), "R8", "done width", which ? done1 : done0, 0);
        repeat (6) @(negedge clk);
        // R9: word held after the access.
        check((which ? rd1 : rd0) == word_now, "R9", "word held",
              which ? rd1 : rd0, word_now);
        // R10: only one access per start, no restart from a mid-access start.
        check((which ? dcnt1 : dcnt0) - d_before == 1, "R10", "done count",
              (which ? dcnt1 : dcnt0) - d_before, 1);
        check(!(which ? cs1 : cs0), "R10", "no second access", which ? cs1 : cs0, 0);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        t_reset();
        t_read(1'b0, 0, 1'b0);
        t_read(1'b0, 63, 1'b0);
        t_read(1'b0, 42, 1'b1);
        t_read(1'b0, 21, 1'b0);
        t_read(1'b1, 255, 1'b0);   // R11: long address, one-clock phases
        t_read(1'b1, 128, 1'b1);
        t_read(1'b1, 90, 1'b0);
        summary_and_end();
    end
endmodule